// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in a small descriptor memory. It reads the descriptor at its current index. If software has marked that descriptor ready, the block presents the descriptor's buffer pointer and length on a frame-send request. When the send side reports completion, the block writes the descriptor back with ready cleared and the completion error code inserted, which returns the descriptor to software. It then moves to the next index, or back to the ring base when the descriptor carries the wrap flag.

A descriptor that is not ready puts the engine into a halted state. The engine stays idle there and does not poll. Software first sets the ring base index, while the engine is halted. It then fills descriptors and pulses the restart command, and fetching resumes at the current index. A graceful stop request lets the frame in flight finish. No new fetch follows, and a stop-complete event is raised. The descriptor memory is outside the block and is reached through a single port whose read data arrives one cycle after the read. The frame data path is reduced to a request/done handshake.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine is halted (`halted`=1), the current index is 0, both event bits are 0 and no send request is raised.
- R2: A descriptor is one 64-bit memory word: status in bits 63:48, length in bits 47:32 and buffer pointer in bits 31:0. Status bit 15 is ready, bit 13 is wrap, bit 12 is interrupt-on-completion, bit 11 is last-buffer and bit 10 is append-CRC. When the fetched word has ready set, `tx_req` rises with `tx_ptr`, `tx_len`, `tx_last` and `tx_crc` taken from it, and descriptors are served in ring order.
- R3: When the fetched descriptor has ready clear, `halted` goes to 1, no request is made and the index stays put. A one-cycle `restart` pulse clears `halted` and fetching resumes at the current index. If a not-ready fetch and `restart` fall in the same cycle, the engine ends up halted.
- R4: After a descriptor completes, the index returns to the ring base if its wrap bit is set. Otherwise it advances by one, modulo DEPTH.
- R5: On completion, the same memory entry is rewritten. Status bit 15 is cleared, status bits 1:0 take `tx_err`, and all other status bits, the length and the pointer are kept.
- R6: While `tx_req` is high and `tx_done` has not come, `tx_req`, `tx_ptr` and `tx_len` stay unchanged.
- R7: While `stop_req` is high, the frame in flight completes and is written back, no further descriptor is fetched, and event bit 1 is set on entering the stopped state. Releasing `stop_req` resumes fetching at the current index.
- R8: Event bit 0 is set when a descriptor with the interrupt flag completes. Writing a 1 to `evt_clr` clears the matching event bit. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: A write of `base_idx` always updates the ring base. It also loads the current index only while the engine is halted. Otherwise the new base takes effect only at the next wrap.
- R10: A stop request made while halted raises event bit 1 and leaves the engine halted after the request is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Write strobe for the ring base index |
| base_idx | input | 4 | New ring base index (log2 DEPTH bits) |
| restart | input | 1 | Clear-halt command, one-cycle pulse |
| stop_req | input | 1 | Graceful stop request, level |
| evt_clr | input | 2 | Write-one-to-clear mask for the event bits |
| evt | output | 2 | Event bits: 0 frame done with interrupt flag, 1 stop complete |
| halted | output | 1 | Engine halted on a not-ready descriptor |
| cur_idx | output | 4 | Current descriptor index |
| dm_en | output | 1 | Descriptor memory access enable |
| dm_we | output | 1 | Descriptor memory write enable |
| dm_addr | output | 4 | Descriptor memory address |
| dm_wdata | output | 64 | Descriptor write-back word |
| dm_rdata | input | 64 | Descriptor read word, valid one cycle after a read |
| tx_req | output | 1 | Frame-send request, held until done |
| tx_ptr | output | 32 | Buffer pointer of the frame |
| tx_len | output | 16 | Length of the frame |
| tx_crc | output | 1 | Append-CRC flag of the frame |
| tx_last | output | 1 | Last-buffer flag of the frame |
| tx_done | input | 1 | Send-complete pulse |
| tx_err | input | 2 | Completion error code, valid with `tx_done` |

## Verification
Two pairs of actions can land in the same cycle. The first is the completion event of an interrupt-flagged frame, which is set during the write-back cycle, together with a software clear of that same event bit. The bench arms its send responder to raise the clear on the very cycle after it returns `tx_done`, which is the write-back cycle, and then expects event bit 0 to remain set. The second is a not-ready fetch together with `restart`. The bench holds `restart` for exactly three cycles, so that its last cycle meets the read-data cycle of a not-ready entry, and then expects `halted` to stay high with no request made.

// File: rtl/txring_pkg.sv
`timescale 1ns/1ps
package txring_pkg;
   localparam int DESC_W   = 64;
   localparam int ST_LSB   = 48;
   localparam int ST_READY = 15;
   localparam int ST_WRAP  = 13;
   localparam int ST_IRQ   = 12;
   localparam int ST_LAST  = 11;
   localparam int ST_CRC   = 10;
   localparam int EV_DONE  = 0;
   localparam int EV_STOP  = 1;
   localparam int EV_N     = 2;

   typedef struct packed {
      logic [15:0] status;
      logic [15:0] len;
      logic [31:0] ptr;
   } txdesc_t;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_RD   = 3'd1,
      S_SEND = 3'd2,
      S_WB   = 3'd3,
      S_STOP = 3'd4
   } txst_e;
endpackage

// File: rtl/txring_idx.sv
`timescale 1ns/1ps
// Ring base register and current index with wrap / modulo advance.
module txring_idx #(
   parameter int DEPTH = 16,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_we_i,
   input  logic [IW-1:0] base_i,
   input  logic          load_i,
   input  logic          adv_i,
   input  logic          wrap_i,
   output logic [IW-1:0] idx_o
);
   logic [IW-1:0] base_q;
   logic [IW-1:0] idx_q;
   logic [IW-1:0] nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign nxt = idx_q + 1'b1;
      end else begin : g_cmp
         assign nxt = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else begin
         if (base_we_i) base_q <= base_i;
         if (adv_i)
            idx_q <= wrap_i ? base_q : nxt;
         else if (base_we_i && load_i)
            idx_q <= base_i;
      end
   end

   assign idx_o = idx_q;

   // R4: a wrapped completion lands on the base held in that cycle
   a_r4_wrap_base: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && wrap_i |=> idx_o == $past(base_q));
   // R9: a base write while not loadable leaves the index alone
   a_r9_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      base_we_i && !load_i && !adv_i |=> $stable(idx_o));
endmodule

// File: rtl/txring_evt.sv
`timescale 1ns/1ps
// Sticky event bits, write-one-to-clear, set has priority.
module txring_evt #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] evt_o
);
   logic [N-1:0] evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~clr_i) | set_i;
   end

   assign evt_o = evt_q;

   // R8: a set is never lost, even against a clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      |set_i |=> (evt_o & $past(set_i)) == $past(set_i));
   // R8: a clear without a set removes the bit
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      |(clr_i & ~set_i) |=> (evt_o & $past(clr_i & ~set_i)) == '0);
endmodule

// File: rtl/txring_engine.sv
`timescale 1ns/1ps
// Transmit descriptor ring walker: fetch, send handshake, write-back.
module txring_engine
   import txring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int ERR_W = 2,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [IW-1:0]     base_idx,
   input  logic              restart,
   input  logic              stop_req,
   input  logic [EV_N-1:0]   evt_clr,
   output logic [EV_N-1:0]   evt,
   output logic              halted,
   output logic [IW-1:0]     cur_idx,
   output logic              dm_en,
   output logic              dm_we,
   output logic [IW-1:0]     dm_addr,
   output logic [DESC_W-1:0] dm_wdata,
   input  logic [DESC_W-1:0] dm_rdata,
   output logic              tx_req,
   output logic [31:0]       tx_ptr,
   output logic [15:0]       tx_len,
   output logic              tx_crc,
   output logic              tx_last,
   input  logic              tx_done,
   input  logic [ERR_W-1:0]  tx_err
);
   generate
      if (DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
         $error("txring_engine: DEPTH must lie in 2..16");
      end
      if (ERR_W < 1 || ERR_W > 8) begin : g_bad_err
         $error("txring_engine: ERR_W must lie in 1..8");
      end
   endgenerate

   txst_e              state_q, state_d;
   logic               halted_q;
   logic               halt_set;
   txdesc_t            rd_desc;
   txdesc_t            cur_q;
   logic [ERR_W-1:0]   err_q;
   logic               adv;
   logic [EV_N-1:0]    ev_set;
   logic [15:0]        st_wb;

   assign rd_desc = dm_rdata;

   always_comb begin
      state_d  = state_q;
      dm_en    = 1'b0;
      dm_we    = 1'b0;
      adv      = 1'b0;
      halt_set = 1'b0;
      ev_set   = '0;
      case (state_q)
         S_IDLE: begin
            if (stop_req) begin
               state_d         = S_STOP;
               ev_set[EV_STOP] = 1'b1;
            end else if (!halted_q) begin
               dm_en   = 1'b1;
               state_d = S_RD;
            end
         end
         S_RD: begin
            if (rd_desc.status[ST_READY]) begin
               state_d = S_SEND;
            end else begin
               halt_set = 1'b1;
               state_d  = S_IDLE;
            end
         end
         S_SEND: if (tx_done) state_d = S_WB;
         S_WB: begin
            dm_en           = 1'b1;
            dm_we           = 1'b1;
            adv             = 1'b1;
            ev_set[EV_DONE] = cur_q.status[ST_IRQ];
            state_d         = S_IDLE;
         end
         S_STOP: if (!stop_req) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         halted_q <= 1'b1;
         cur_q    <= '0;
         err_q    <= '0;
      end else begin
         state_q <= state_d;
         if (halt_set)     halted_q <= 1'b1;
         else if (restart) halted_q <= 1'b0;
         if (state_q == S_RD && rd_desc.status[ST_READY]) cur_q <= rd_desc;
         if (state_q == S_SEND && tx_done) err_q <= tx_err;
      end
   end

   always_comb begin
      st_wb              = cur_q.status;
      st_wb[ST_READY]    = 1'b0;
      st_wb[ERR_W-1:0]   = err_q;
   end

   txring_idx #(.DEPTH(DEPTH)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we_i (base_we),
      .base_i    (base_idx),
      .load_i    (halted_q),
      .adv_i     (adv),
      .wrap_i    (cur_q.status[ST_WRAP]),
      .idx_o     (cur_idx)
   );

   txring_evt #(.N(EV_N)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set),
      .clr_i (evt_clr),
      .evt_o (evt)
   );

   assign halted   = halted_q;
   assign dm_addr  = cur_idx;
   assign dm_wdata = {st_wb, cur_q.len, cur_q.ptr};
   assign tx_req   = (state_q == S_SEND);
   assign tx_ptr   = cur_q.ptr;
   assign tx_len   = cur_q.len;
   assign tx_crc   = cur_q.status[ST_CRC];
   assign tx_last  = cur_q.status[ST_LAST];

   // R3: a halted engine never requests a send
   a_r3_quiet_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !tx_req);
   // R5: every write-back hands the descriptor to software
   a_r5_owner_back: assert property (@(posedge clk) disable iff (!rst_n)
      dm_we |-> !dm_wdata[ST_LSB + ST_READY]);
   // R6: request fields hold until done
   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && !tx_done |=> tx_req && $stable(tx_ptr) && $stable(tx_len));
   // R7: stopped engine neither sends nor touches memory
   a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_STOP |-> !tx_req && !dm_en);
endmodule

// File: tb/txring_engine_tb.sv
`timescale 1ns/1ps
module txring_engine_tb_top;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_we = 1'b0;
   logic [3:0]  base_idx = '0;
   logic        restart = 1'b0;
   logic        stop_req = 1'b0;
   logic [1:0]  evt_clr = '0;
   logic [1:0]  evt;
   logic        halted;
   logic [3:0]  cur_idx;
   logic        dm_en, dm_we;
   logic [3:0]  dm_addr;
   logic [63:0] dm_wdata;
   logic [63:0] dm_rdata = '0;
   logic        tx_req;
   logic [31:0] tx_ptr;
   logic [15:0] tx_len;
   logic        tx_crc, tx_last;
   logic        tx_done = 1'b0;
   logic [1:0]  tx_err = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   txring_engine #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_idx(base_idx),
      .restart(restart), .stop_req(stop_req), .evt_clr(evt_clr), .evt(evt),
      .halted(halted), .cur_idx(cur_idx), .dm_en(dm_en), .dm_we(dm_we),
      .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
      .tx_req(tx_req), .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_crc(tx_crc),
      .tx_last(tx_last), .tx_done(tx_done), .tx_err(tx_err)
   );

   // descriptor memory model, one-cycle read latency
   logic [63:0] mem [DEPTH];
   logic        tb_we = 1'b0;
   logic [3:0]  tb_addr = '0;
   logic [63:0] tb_wdata = '0;
   always @(posedge clk) begin
      if (tb_we) mem[tb_addr] <= tb_wdata;
      else if (dm_en) begin
         if (dm_we) mem[dm_addr] <= dm_wdata;
         else       dm_rdata <= mem[dm_addr];
      end
   end

   // send responder and event-clear driver
   logic [31:0] lg_ptr [128];
   logic [31:0] lg_ptr0 [128];
   logic [15:0] lg_len [128];
   logic        lg_crc [128];
   logic        lg_last [128];
   logic [1:0]  lg_err [128];
   int          lg_n = 0;
   int unsigned dly = 0;
   bit          busy = 0;
   int          clr_seq = 0, clr_seen = 0, coll_seq = 0, coll_seen = 0;
   logic [1:0]  clr_mask = '0;

   always @(negedge clk) begin
      evt_clr = '0;
      if (clr_seq != clr_seen) begin
         evt_clr  = clr_mask;
         clr_seen = clr_seq;
      end
      if (tx_done) begin
         tx_done = 1'b0;
         if (coll_seq != coll_seen) begin
            evt_clr[0] = 1'b1;
            coll_seen  = coll_seq;
         end
      end else if (tx_req) begin
         if (!busy) begin
            busy = 1;
            lg_ptr0[lg_n] = tx_ptr;
         end
         if (dly == 0) begin
            lg_ptr[lg_n]  = tx_ptr;
            lg_len[lg_n]  = tx_len;
            lg_crc[lg_n]  = tx_crc;
            lg_last[lg_n] = tx_last;
            tx_err        = 2'($urandom);
            lg_err[lg_n]  = tx_err;
            lg_n          = lg_n + 1;
            tx_done       = 1'b1;
            busy          = 0;
            dly           = $urandom % 4;
         end else begin
            dly = dly - 1;
         end
      end
   end

   function automatic logic [63:0] wb_word(logic [63:0] w, logic [1:0] e);
      logic [15:0] st;
      st = (w[63:48] & 16'h7FFC) | {14'd0, e};
      return {st, w[47:0]};
   endfunction

   function automatic logic [3:0] step_idx(logic [3:0] i, logic [15:0] st, logic [3:0] b);
      return st[13] ? b : 4'(i + 1);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_word(logic [3:0] a, logic [63:0] w);
      tb_we = 1'b1; tb_addr = a; tb_wdata = w;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic set_base(logic [3:0] b);
      base_we = 1'b1; base_idx = b;
      @(negedge clk);
      base_we = 1'b0;
   endtask

   task automatic pulse_restart();
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic clear_evts(logic [1:0] m);
      clr_mask = m;
      clr_seq  = clr_seq + 1;
      tick(3);
   endtask

   task automatic wait_halt(string req);
      int n = 0;
      while (!halted && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(halted, req, "halt reached", halted, 1);
   endtask

   task automatic fill_idle();
      for (int i = 0; i < DEPTH; i++)
         put_word(4'(i), {16'($urandom) & 16'h7FFC, 16'($urandom), 32'($urandom)});
   endtask

   task automatic rand_round();
      int unsigned b, len_n;
      bit wr, irq_any;
      int start;
      logic [63:0] ew [8];
      logic [3:0]  ei [8];
      logic [3:0]  nx;
      logic [15:0] st;
      b = $urandom % DEPTH;
      len_n = $urandom % 6;
      wr = (len_n > 0) && ($urandom % 2 == 1);
      fill_idle();
      nx = 4'(b);
      irq_any = 0;
      for (int k = 0; k < int'(len_n); k++) begin
         st = 16'h8000 | (16'($urandom) & 16'h1C00);
         if (wr && k == int'(len_n) - 1) st = st | 16'h2000;
         ew[k] = {st, 16'($urandom), 32'($urandom) & 32'hFFFF_FFF8};
         ei[k] = nx;
         irq_any = irq_any | st[12];
         put_word(nx, ew[k]);
         nx = step_idx(nx, st, 4'(b));
      end
      set_base(4'(b));
      chk(cur_idx == 4'(b), "R9", "base load while halted", cur_idx, b);
      clear_evts(2'b11);
      start = lg_n;
      pulse_restart();
      tick(1);
      wait_halt("R3");
      chk(lg_n - start == int'(len_n), "R2", "frames sent", lg_n - start, len_n);
      for (int k = 0; k < int'(len_n) && k < lg_n - start; k++) begin
         chk({lg_ptr[start+k], lg_len[start+k], lg_crc[start+k], lg_last[start+k]} ==
             {ew[k][31:0], ew[k][47:32], ew[k][48+10], ew[k][48+11]},
             "R2", "request fields", lg_ptr[start+k], ew[k][31:0]);
         chk(lg_ptr0[start+k] == lg_ptr[start+k], "R6", "ptr held", lg_ptr[start+k], lg_ptr0[start+k]);
         chk(mem[ei[k]] == wb_word(ew[k], lg_err[start+k]), "R5", "write-back word",
             mem[ei[k]], wb_word(ew[k], lg_err[start+k]));
      end
      chk(cur_idx == nx, "R4", "final index", cur_idx, nx);
      chk(evt[0] == irq_any, "R8", "done event", evt[0], irq_any);
      clear_evts(2'b11);
      chk(evt == 2'b00, "R8", "events cleared", evt, 0);
   endtask

   initial begin
      int start;
      void'($urandom(32'd4242));
      tick(3);
      chk(halted == 1'b1, "R1", "halted at reset", halted, 1);
      chk(cur_idx == 4'd0, "R1", "index at reset", cur_idx, 0);
      chk(evt == 2'b00 && tx_req == 1'b0, "R1", "events/request at reset", {evt, tx_req}, 0);
      rst_n = 1'b1;
      tick(2);

      for (int r = 0; r < 10; r++) rand_round();

      // R8 same-cycle: done event set vs software clear
      fill_idle();
      put_word(4'd2, {16'h9000, 16'd64, 32'h0000_1000});
      set_base(4'd2);
      clear_evts(2'b11);
      coll_seq = coll_seq + 1;
      pulse_restart();
      tick(1);
      wait_halt("R3");
      chk(evt[0] == 1'b1, "R8", "set wins over clear", evt[0], 1);
      chk(cur_idx == 4'd3, "R4", "step after single frame", cur_idx, 3);
      clear_evts(2'b01);
      chk(evt[0] == 1'b0, "R8", "clear alone", evt[0], 0);

      // R3 same-cycle: not-ready fetch vs restart
      start = lg_n;
      restart = 1'b1;
      tick(3);
      restart = 1'b0;
      tick(4);
      chk(halted == 1'b1, "R3", "halt wins over restart", halted, 1);
      chk(lg_n == start && cur_idx == 4'd3, "R3", "no send, index kept", cur_idx, 3);

      // R7 graceful stop mid-ring, R9 base write while running
      fill_idle();
      put_word(4'd4, {16'h8400, 16'd100, 32'h0000_2000});
      put_word(4'd5, {16'h8800, 16'd101, 32'h0000_3000});
      put_word(4'd6, {16'hA000, 16'd102, 32'h0000_4000});
      set_base(4'd4);
      clear_evts(2'b11);
      start = lg_n;
      pulse_restart();
      begin
         int n = 0;
         while (!tx_req && n < 100) begin @(negedge clk); n++; end
      end
      stop_req = 1'b1;
      begin
         int n = 0;
         while (!evt[1] && n < 100) begin @(negedge clk); n++; end
      end
      tick(2);
      chk(evt[1] == 1'b1, "R7", "stop event", evt[1], 1);
      chk(lg_n - start == 1, "R7", "only frame in flight sent", lg_n - start, 1);
      chk(cur_idx == 4'd5 && halted == 1'b0 && tx_req == 1'b0, "R7", "stopped after write-back",
          cur_idx, 5);
      chk(mem[4] == wb_word({16'h8400, 16'd100, 32'h0000_2000}, lg_err[start]), "R5",
          "stopped frame written back", mem[4], 0);
      set_base(4'd9);
      tick(1);
      chk(cur_idx == 4'd5, "R9", "base write while running keeps index", cur_idx, 5);
      stop_req = 1'b0;
      tick(1);
      wait_halt("R7");
      chk(lg_n - start == 3, "R7", "resume after release", lg_n - start, 3);
      chk(cur_idx == 4'd9, "R4", "wrap uses new base", cur_idx, 9);

      // R10 stop while halted
      clear_evts(2'b11);
      start = lg_n;
      stop_req = 1'b1;
      tick(3);
      chk(evt[1] == 1'b1 && halted == 1'b1, "R10", "stop event while halted", {evt[1], halted}, 3);
      stop_req = 1'b0;
      tick(4);
      chk(halted == 1'b1 && lg_n == start, "R10", "still halted after release", halted, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end
endmodule